// File: doc/BRIEF.md
# Fixed-Period PWM Current Chopper

This block regulates the current in one winding of an H-bridge. It uses a free-running period counter to split time into fixed PWM periods. Every period starts by driving current through the winding in the direction set by the phase bit. A comparator that has already been synchronised reports when the sensed current passes the target. That report is ignored during a blanking window at the start of drive, and this window also sets the minimum on time. Once the window has passed, a trip ends drive and the bridge enters a decay phase for the rest of the period.

Two decay behaviours are available. Slow decay turns on both low-side switches so that the current recirculates. Mixed decay is used only when mixed mode is selected and the indexer reports a falling target. It first reverses the bridge (fast decay) and then falls back to slow decay at a fixed fraction of the period. If the zero-current flag rises during fast decay, the bridge coasts with every switch off, so that no reverse current builds up. Each leg has its own dead-band stage. Whenever the commanded state of a leg changes, that stage holds both of the leg's switches off for a programmed number of clocks. All timing is expressed in clock cycles, and the parameter defaults assume a 100 MHz clock: a 2000-cycle period (50 kHz), a 375-cycle blanking window (3.75 us) and a mix point at 75 %.

Top module: `pwm_chopper`

## Requirements
- R1: After reset, all four gate enables stay low until the first period boundary, which comes PERIOD_CYC cycles after reset is released.
- R2: The period counter wraps every PERIOD_CYC cycles. Every period starts in drive. The phase bit, and the product of the mode select and the falling flag, are captured at the edge where the counter wraps, and they hold for the whole period.
- R3: In drive with a captured phase of 1, leg 1 high side and leg 2 low side are on. With a phase of 0, leg 2 high side and leg 1 low side are on.
- R4: A trip seen while the period count is below BLANK_CYC has no effect, and drive continues.
- R5: A trip seen at a count of BLANK_CYC or above ends drive. If slow decay was captured, or the target was not falling, both low sides turn on and stay on until the period ends.
- R6: If mixed mode and a falling target were captured, a trip before the mix point reverses the bridge. With a phase of 1, leg 1 low side and leg 2 high side turn on. Reverse drive never runs at or past the mix point.
- R7: If the zero-current flag is high during fast decay, all four switches turn off until the mix point.
- R8: No leg ever has its high and low switches on together. Before any switch turns on, both switches of its leg have been off for at least DEAD_CYC consecutive cycles.
- R9: When the bridge enable is low or the zero-target flag is high, all four gate enables are low on the next cycle. The period counter keeps running, and the state machine keeps running too.
- R10: The mix point is PERIOD_CYC*MIX_PCT/100 cycles into the period. From that point on, mixed decay becomes slow decay (both low sides on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Synchronised comparator output, high when the sensed current is above target |
| cur_zero_i | input | 1 | Winding current is near zero |
| phase_i | input | 1 | Drive direction: 1 drives positive current (leg 1 high) |
| tgt_zero_i | input | 1 | Indexer target is zero; forces all switches off |
| bridge_en_i | input | 1 | Bridge enable; low forces all switches off |
| mixed_sel_i | input | 1 | 0 selects slow decay, 1 selects mixed decay |
| tgt_falling_i | input | 1 | Indexer target is decreasing |
| leg1_hi_o | output | 1 | Gate enable, leg 1 high side |
| leg1_lo_o | output | 1 | Gate enable, leg 1 low side |
| leg2_hi_o | output | 1 | Gate enable, leg 2 high side |
| leg2_lo_o | output | 1 | Gate enable, leg 2 low side |

## Verification
Some properties are checked on every cycle: that no leg has both of its switches on, the dead-band gap before each turn-on, that disabling the bridge darkens the outputs on the next cycle, that the blanking window holds drive, that every period boundary restarts drive, and that reverse drive stays before the mix point. Only the bench's scenarios can show the rest: the exact gate pattern for each phase and decay choice, capture of phase and mode at the boundary even when the inputs move in the middle of a period, the coast reaction to the zero flag, and the exact cycle at which a trip or the mix point changes the outputs. The bench covers these by comparing every cycle against its own model of the requirements.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_FAST,
    ST_COAST,
    ST_SLOW
  } chop_st_e;

  typedef enum logic [1:0] {
    LEG_OFF,
    LEG_HI,
    LEG_LO
  } leg_cmd_e;

  typedef struct packed {
    leg_cmd_e l1;
    leg_cmd_e l2;
  } bridge_cmd_t;

  // Cycle index at which mixed decay hands over to slow decay
  function automatic int mix_point(input int period, input int pct);
    return (period * pct) / 100;
  endfunction

  // Trip is honoured once the blanking window has elapsed
  function automatic logic past_blank(input int cnt, input int blank);
    return cnt >= blank;
  endfunction

  // True when the following cycle still lies before the mix point
  function automatic logic next_before_mix(input int cnt, input int mix);
    return (cnt + 1) < mix;
  endfunction

  // Leg commands per decay state and captured phase
  function automatic bridge_cmd_t leg_pattern(input chop_st_e st, input logic ph);
    bridge_cmd_t c;
    c.l1 = LEG_OFF;
    c.l2 = LEG_OFF;
    case (st)
      ST_DRIVE: begin
        c.l1 = ph ? LEG_HI : LEG_LO;
        c.l2 = ph ? LEG_LO : LEG_HI;
      end
      ST_FAST: begin
        c.l1 = ph ? LEG_LO : LEG_HI;
        c.l2 = ph ? LEG_HI : LEG_LO;
      end
      ST_SLOW: begin
        c.l1 = LEG_LO;
        c.l2 = LEG_LO;
      end
      default: begin
        c.l1 = LEG_OFF;
        c.l2 = LEG_OFF;
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD_CYC = 2000,
  parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/chop_decay_fsm.sv
module chop_decay_fsm
  import chop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wrap_i,
  input  logic     blank_done_i,
  input  logic     pre_mix_i,
  input  logic     trip_i,
  input  logic     cur_zero_i,
  input  logic     phase_i,
  input  logic     mix_req_i,
  output chop_st_e st_o,
  output logic     ph_o
);

  chop_st_e st_q;
  logic     ph_q;
  logic     mix_q;

  assign st_o = st_q;
  assign ph_o = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      mix_q <= 1'b0;
    end else if (wrap_i) begin
      st_q  <= ST_DRIVE;
      ph_q  <= phase_i;
      mix_q <= mix_req_i;
    end else begin
      case (st_q)
        ST_DRIVE: begin
          if (blank_done_i && trip_i) begin
            st_q <= (mix_q && pre_mix_i) ? ST_FAST : ST_SLOW;
          end
        end
        ST_FAST: begin
          if (!pre_mix_i) begin
            st_q <= ST_SLOW;
          end else if (cur_zero_i) begin
            st_q <= ST_COAST;
          end
        end
        ST_COAST: begin
          if (!pre_mix_i) begin
            st_q <= ST_SLOW;
          end
        end
        default: st_q <= st_q;
      endcase
    end
  end

endmodule

// File: rtl/chop_leg_deadband.sv
module chop_leg_deadband
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter int DW       = $clog2(DEAD_CYC + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_e tgt_i,
  output logic     hi_o,
  output logic     lo_o
);

  leg_cmd_e      held_q;
  logic [DW-1:0] gap_q;
  logic          gap_idle;

  assign gap_idle = (gap_q == '0);
  assign hi_o     = gap_idle && (held_q == LEG_HI);
  assign lo_o     = gap_idle && (held_q == LEG_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= LEG_OFF;
      gap_q  <= '0;
    end else if (tgt_i != held_q) begin
      held_q <= tgt_i;
      gap_q  <= DW'(DEAD_CYC);
    end else if (!gap_idle) begin
      gap_q  <= gap_q - DW'(1);
    end
  end

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int DEAD_CYC   = 4,
  parameter int MIX_PCT    = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic cur_zero_i,
  input  logic phase_i,
  input  logic tgt_zero_i,
  input  logic bridge_en_i,
  input  logic mixed_sel_i,
  input  logic tgt_falling_i,
  output logic leg1_hi_o,
  output logic leg1_lo_o,
  output logic leg2_hi_o,
  output logic leg2_lo_o
);

  localparam int CNT_W   = $clog2(PERIOD_CYC);
  localparam int MIX_CYC = mix_point(PERIOD_CYC, MIX_PCT);
  localparam int N_LEG   = 2;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic             blank_done;
  logic             pre_mix;
  chop_st_e         st_q;
  logic             ph_q;
  logic             bridge_on;
  bridge_cmd_t      cmd;
  leg_cmd_e         leg_tgt [N_LEG];
  logic             gate_hi [N_LEG];
  logic             gate_lo [N_LEG];

  chop_period_timer #(
    .PERIOD_CYC (PERIOD_CYC),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  assign blank_done = past_blank(int'(cnt_q), BLANK_CYC);
  assign pre_mix    = next_before_mix(int'(cnt_q), MIX_CYC);

  chop_decay_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrap_i       (wrap),
    .blank_done_i (blank_done),
    .pre_mix_i    (pre_mix),
    .trip_i       (trip_i),
    .cur_zero_i   (cur_zero_i),
    .phase_i      (phase_i),
    .mix_req_i    (mixed_sel_i & tgt_falling_i),
    .st_o         (st_q),
    .ph_o         (ph_q)
  );

  assign bridge_on  = bridge_en_i && !tgt_zero_i;
  assign cmd        = leg_pattern(st_q, ph_q);
  assign leg_tgt[0] = bridge_on ? cmd.l1 : LEG_OFF;
  assign leg_tgt[1] = bridge_on ? cmd.l2 : LEG_OFF;

  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    chop_leg_deadband #(
      .DEAD_CYC (DEAD_CYC)
    ) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .tgt_i (leg_tgt[g]),
      .hi_o  (gate_hi[g]),
      .lo_o  (gate_lo[g])
    );
  end

  assign leg1_hi_o = gate_hi[0];
  assign leg1_lo_o = gate_lo[0];
  assign leg2_hi_o = gate_hi[1];
  assign leg2_lo_o = gate_lo[1];

endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 2000,
  parameter int BLANK_CYC  = 375,
  parameter int DEAD_CYC   = 4,
  parameter int MIX_PCT    = 75,
  parameter int CNT_W      = $clog2(PERIOD_CYC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tgt_zero,
  input logic             l1_hi,
  input logic             l1_lo,
  input logic             l2_hi,
  input logic             l2_lo,
  input chop_st_e         st,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap
);

  localparam int MIX_CYC = mix_point(PERIOD_CYC, MIX_PCT);
  localparam int RW      = $clog2(DEAD_CYC + 1) + 1;

  logic [RW-1:0] dark1;
  logic [RW-1:0] dark2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dark1 <= '0;
      dark2 <= '0;
    end else begin
      if (l1_hi || l1_lo) dark1 <= '0;
      else if (int'(dark1) < DEAD_CYC) dark1 <= dark1 + RW'(1);
      if (l2_hi || l2_lo) dark2 <= '0;
      else if (int'(dark2) < DEAD_CYC) dark2 <= dark2 + RW'(1);
    end
  end

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !(l1_hi || l1_lo || l2_hi || l2_lo)); // R1

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (st == ST_DRIVE && cnt == '0)); // R2

  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRIVE && int'(cnt) < BLANK_CYC && !wrap) |=> (st == ST_DRIVE)); // R4

  AST_SLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLOW && !wrap) |=> (st == ST_SLOW)); // R5

  AST_FAST_BEFORE_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FAST || st == ST_COAST) |-> (int'(cnt) < MIX_CYC)); // R6

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hi && l1_lo) && !(l2_hi && l2_lo)); // R8

  AST_LEG1_DEADBAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(l1_hi) || $rose(l1_lo)) |-> (int'(dark1) >= DEAD_CYC)); // R8

  AST_LEG2_DEADBAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(l2_hi) || $rose(l2_lo)) |-> (int'(dark2) >= DEAD_CYC)); // R8

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || tgt_zero) |=> !(l1_hi || l1_lo || l2_hi || l2_lo)); // R9

endmodule

bind pwm_chopper pwm_chopper_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .BLANK_CYC  (BLANK_CYC),
  .DEAD_CYC   (DEAD_CYC),
  .MIX_PCT    (MIX_PCT),
  .CNT_W      (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (bridge_en_i),
  .tgt_zero (tgt_zero_i),
  .l1_hi    (leg1_hi_o),
  .l1_lo    (leg1_lo_o),
  .l2_hi    (leg2_hi_o),
  .l2_lo    (leg2_lo_o),
  .st       (st_q),
  .cnt      (cnt_q),
  .wrap     (wrap)
);

// File: tb/tb_pwm_chopper.sv
module tb_pwm_chopper;

  localparam int P  = 200;
  localparam int B  = 30;
  localparam int D  = 3;
  localparam int MP = 75;
  localparam int M  = (P * MP) / 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, trip, czero, ph, tz, en, msel, fall;
  logic l1h, l1l, l2h, l2l;

  pwm_chopper #(
    .PERIOD_CYC (P),
    .BLANK_CYC  (B),
    .DEAD_CYC   (D),
    .MIX_PCT    (MP)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .trip_i        (trip),
    .cur_zero_i    (czero),
    .phase_i       (ph),
    .tgt_zero_i    (tz),
    .bridge_en_i   (en),
    .mixed_sel_i   (msel),
    .tgt_falling_i (fall),
    .leg1_hi_o     (l1h),
    .leg1_lo_o     (l1l),
    .leg2_hi_o     (l2h),
    .leg2_lo_o     (l2l)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model. Modes: 0 idle, 1 drive, 2 reverse, 3 coast, 4 recirculate.
  // Leg wants: 0 off, 1 high, 2 low.
  int    m_cnt, m_st, m_ph, m_mx;
  int    m_last [2];
  int    m_dc   [2];
  string m_tag;

  function automatic int leg_want(int st, int p, int leg, bit on);
    int hi_leg;
    if (!on) return 0;
    case (st)
      1: begin hi_leg = p ? 0 : 1; return (leg == hi_leg) ? 1 : 2; end
      2: begin hi_leg = p ? 1 : 0; return (leg == hi_leg) ? 1 : 2; end
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_st = 0; m_ph = 0; m_mx = 0;
    for (int i = 0; i < 2; i++) begin m_last[i] = 0; m_dc[i] = 0; end
    m_tag = "R1";
  endtask

  task automatic model_step();
    int w [2];
    bit on;
    int nxt;
    int prev_st;
    on = en && !tz;
    prev_st = m_st;
    for (int i = 0; i < 2; i++) w[i] = leg_want(m_st, m_ph, i, on);
    for (int i = 0; i < 2; i++) begin
      if (w[i] != m_last[i]) begin m_last[i] = w[i]; m_dc[i] = D; end
      else if (m_dc[i] > 0) m_dc[i] = m_dc[i] - 1;
    end
    nxt = m_cnt + 1;
    if (m_cnt == P - 1) begin
      m_st = 1; m_ph = ph; m_mx = (msel && fall) ? 1 : 0;
    end else begin
      case (m_st)
        1: if (m_cnt >= B && trip) m_st = (m_mx == 1 && nxt < M) ? 2 : 4;
        2: if (nxt >= M) m_st = 4; else if (czero) m_st = 3;
        3: if (nxt >= M) m_st = 4;
        default: ;
      endcase
    end
    m_cnt = (m_cnt == P - 1) ? 0 : nxt;
    if (prev_st == 0) m_tag = "R1";
    else if (!on) m_tag = "R9";
    else if (m_dc[0] > 0 || m_dc[1] > 0) m_tag = (m_cnt <= D + 1) ? "R2" : "R8";
    else if (prev_st == 1) m_tag = (trip && m_cnt <= B + 1) ? "R4" : "R3";
    else if (prev_st == 2) m_tag = "R6";
    else if (prev_st == 3) m_tag = "R7";
    else m_tag = (m_mx == 1) ? "R10" : "R5";
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check_outputs();
    logic [3:0] exp_v, act_v;
    exp_v = {(m_dc[0] == 0 && m_last[0] == 1), (m_dc[0] == 0 && m_last[0] == 2),
             (m_dc[1] == 0 && m_last[1] == 1), (m_dc[1] == 0 && m_last[1] == 2)};
    act_v = {l1h, l1l, l2h, l2l};
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s cnt=%0d gates actual=%b expected=%b", m_tag, m_cnt, act_v, exp_v);
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    check_outputs();
  endtask

  // One aligned period; inputs set each cycle from the upcoming count
  task automatic run_period(int trip_at, int zero_at, bit p, bit ms, bit fl,
                            bit e, bit z, bit jit);
    while (m_cnt != P - 1) cycle();
    ph = p; msel = ms; fall = fl; en = e; tz = z;
    trip = (m_cnt >= trip_at); czero = (m_cnt >= zero_at);
    for (int k = 0; k < P; k++) begin
      cycle();
      trip  = (m_cnt >= trip_at);
      czero = (m_cnt >= zero_at);
      if (jit) begin
        if ($urandom_range(0, 39) == 0) ph = ~ph;
        if ($urandom_range(0, 39) == 0) msel = ~msel;
        if ($urandom_range(0, 39) == 0) fall = ~fall;
        if ($urandom_range(0, 199) == 0) en = ~en;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; trip = 0; czero = 0; ph = 1; tz = 0; en = 1; msel = 0; fall = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, then a full idle period with an active trip
    check_outputs();
    trip = 1;
    repeat (P - 2) cycle();
    // R4/R5: trip held high from period start, slow decay, both phases
    run_period(0, P + 10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_period(0, P + 10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R3: no trip, drive all period
    run_period(P + 10, P + 10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R6/R10: mixed falling, trip at 60, no zero
    run_period(60, P + 10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R7: mixed falling, zero flag during reverse drive
    run_period(50, 100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R6/R10: trip after mix point goes straight to recirculation
    run_period(M + 5, P + 10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R9: disabled and zero-target periods, then back on
    run_period(40, P + 10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_period(40, P + 10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run_period(40, P + 10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // Random periods with mid-period input motion (R2 capture)
    for (int n = 0; n < 250; n++) begin
      run_period($urandom_range(0, P + P / 4), $urandom_range(B, P),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0),
                 ($urandom_range(0, 19) == 0), 1'b1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule